// File: doc/BRIEF.md
# Interrupt Destination Bitmask Generator

This block decides which cores an interrupt message reaches. On a request strobe it takes a destination ID, a physical or logical addressing choice, a two-bit shorthand code and a lowest-priority flag. It then sets one bit for each targeted core, out of `N` cores. Each core feeds in its own routing state: an 8-bit ID, a 32-bit extended ID, an 8-bit logical ID, a 32-bit extended logical ID, a flag that picks flat or cluster grouping, an extended-mode flag and a presence bit.

All matching is combinational. The mask is captured in a register and announced by a single-cycle `mask_valid` pulse on the clock after the request. A request may be issued every cycle. The mask stays unchanged until the next request.

Top module: `dest_mask_gen`

## Requirements
- R1: While `rst_n` is low, `mask_valid` is 0 and `target_mask` is all zeros.
- R2: A request sampled on `req_valid` at one rising edge gives `mask_valid`=1 for exactly the following cycle. With no request, `mask_valid` is 0 and `target_mask` keeps its last value. Back-to-back requests each produce their own result.
- R3: Shorthand code 1 targets only the core whose index is `sender_idx`.
- R4: Shorthand code 2 targets every core. Shorthand code 3 targets every core except `sender_idx`. Shorthand code 0 uses destination matching (R5 to R10).
- R5: In physical addressing (`dest_logical`=0), a core with `core_ext`=1 matches when its 32-bit extended ID equals `dest_id`. A core with `core_ext`=0 matches when its 8-bit ID equals `dest_id[7:0]`.
- R6: In physical addressing, `dest_id`=32'hFFFF_FFFF targets every core. `dest_id`=32'h0000_00FF also targets every core with `core_ext`=0.
- R7: In logical addressing, a core with `core_ext`=0 and `core_cluster`=0 (flat grouping) matches when `dest_id[7:0]` AND its logical ID is non-zero.
- R8: In logical addressing, a core with `core_ext`=0 and `core_cluster`=1 matches when two conditions hold. First, `dest_id[7:4]` equals bits [7:4] of its logical ID, or equals 4'hF. Second, `dest_id[3:0]` AND bits [3:0] of its logical ID is non-zero.
- R9: In logical addressing, a core with `core_ext`=1 matches when `dest_id[31:16]` equals bits [31:16] of its extended logical ID and `dest_id[15:0]` AND bits [15:0] of that ID is non-zero.
- R10: In logical addressing, `dest_id`=32'hFFFF_FFFF targets every extended-mode core. Every other core is still matched under R7 or R8 using `dest_id[7:0]`=8'hFF.
- R11: With `lowest_pri`=1, only the lowest-indexed set bit of the mask survives. An empty mask stays empty.
- R12: A core whose `core_present` bit is 0 is never targeted, whatever the shorthand or destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| dest_id | input | 32 | Destination ID |
| dest_logical | input | 1 | 1 = logical addressing, 0 = physical |
| shorthand | input | 2 | 0 match, 1 self, 2 all, 3 all but self |
| lowest_pri | input | 1 | Lowest-priority delivery: keep lowest-indexed target |
| sender_idx | input | IDXW | Index of the sending core |
| core_present | input | N | Core exists |
| core_ext | input | N | Core runs in extended mode |
| core_cluster | input | N | 1 = cluster grouping, 0 = flat grouping |
| core_id | input | 8*N | Packed 8-bit IDs, core i at [8i+7:8i] |
| core_xid | input | 32*N | Packed extended IDs, core i at [32i+31:32i] |
| core_ldr | input | 8*N | Packed logical IDs |
| core_xldr | input | 32*N | Packed extended logical IDs |
| mask_valid | output | 1 | One-cycle result strobe |
| target_mask | output | N | Registered target bitmask, bit i = core i |

## Verification
The case hardest to reach from the ports is a broadcast ID that is read differently by each core in one request. An all-ones logical destination hits the extended core through the broadcast rule, a flat core through its AND, and a cluster core through cluster 4'hF. The 8-bit physical broadcast must hit the ordinary cores and skip the extended one. The stimulus gives one fixed set of cores all three personalities together, so a single request shows every path of that kind. It also picks a physical ID whose low byte matches an ordinary core while its upper bits differ, which separates the 8-bit compare from the 32-bit one.

// File: rtl/dest_mask_gen.sv
module dest_mask_gen #(
  parameter int N = 8,
  localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [31:0]     dest_id,
  input  logic            dest_logical,
  input  logic [1:0]      shorthand,
  input  logic            lowest_pri,
  input  logic [IDXW-1:0] sender_idx,
  input  logic [N-1:0]    core_present,
  input  logic [N-1:0]    core_ext,
  input  logic [N-1:0]    core_cluster,
  input  logic [8*N-1:0]  core_id,
  input  logic [32*N-1:0] core_xid,
  input  logic [8*N-1:0]  core_ldr,
  input  logic [32*N-1:0] core_xldr,
  output logic            mask_valid,
  output logic [N-1:0]    target_mask
);

  logic all_ones, low_ff;
  logic [N-1:0] sel, raw, pick;

  assign all_ones = (dest_id == 32'hFFFF_FFFF);
  assign low_ff   = (dest_id == 32'h0000_00FF);

  for (genvar i = 0; i < N; i++) begin : g_core
    logic [7:0]  id8, ldr;
    logic [31:0] xid, xldr;
    logic phys_hit, log_hit, cl_hit, flat_hit, xl_hit;

    assign id8  = core_id[8*i +: 8];
    assign ldr  = core_ldr[8*i +: 8];
    assign xid  = core_xid[32*i +: 32];
    assign xldr = core_xldr[32*i +: 32];

    assign phys_hit = all_ones
                    | (core_ext[i] ? (xid == dest_id)
                                   : ((id8 == dest_id[7:0]) | low_ff));

    assign flat_hit = |(dest_id[7:0] & ldr);
    assign cl_hit   = ((dest_id[7:4] == 4'hF) | (dest_id[7:4] == ldr[7:4]))
                    & (|(dest_id[3:0] & ldr[3:0]));
    assign xl_hit   = all_ones
                    | ((dest_id[31:16] == xldr[31:16]) & (|(dest_id[15:0] & xldr[15:0])));

    assign log_hit  = core_ext[i] ? xl_hit : (core_cluster[i] ? cl_hit : flat_hit);

    always_comb begin
      unique case (shorthand)
        2'd0: sel[i] = dest_logical ? log_hit : phys_hit;
        2'd1: sel[i] = (sender_idx == IDXW'(i));
        2'd2: sel[i] = 1'b1;
        default: sel[i] = (sender_idx != IDXW'(i));
      endcase
    end
  end

  assign raw  = sel & core_present;
  assign pick = lowest_pri ? (raw & (~raw + N'(1))) : raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_valid  <= 1'b0;
      target_mask <= '0;
    end else begin
      mask_valid <= req_valid;
      if (req_valid) target_mask <= pick;
    end
  end

endmodule

module dest_mask_gen_chk #(
  parameter int N = 8,
  localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [1:0]      shorthand,
  input logic            lowest_pri,
  input logic [IDXW-1:0] sender_idx,
  input logic [N-1:0]    core_present,
  input logic            mask_valid,
  input logic [N-1:0]    target_mask
);

  // R2
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> mask_valid);

  // R2
  idle_holds_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!mask_valid && $stable(target_mask)));

  // R12
  absent_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ((target_mask & ~$past(core_present)) == '0));

  // R11
  lowest_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && lowest_pri) |=> ($countones(target_mask) <= 1));

  // R3
  self_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && shorthand == 2'd1) |=> ((target_mask >> $past(sender_idx)) <= 1));

  // R4
  others_skip_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && shorthand == 2'd3) |=> (((target_mask >> $past(sender_idx)) & 1) == 0));

  // R4
  all_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && shorthand == 2'd2 && !lowest_pri) |=> (target_mask == $past(core_present)));

endmodule

bind dest_mask_gen dest_mask_gen_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .shorthand(shorthand),
  .lowest_pri(lowest_pri), .sender_idx(sender_idx), .core_present(core_present),
  .mask_valid(mask_valid), .target_mask(target_mask)
);

// File: tb/dest_mask_gen_test.sv
module dest_mask_gen_test;
  localparam int N = 4;
  localparam int IDXW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [31:0] dest_id = '0;
  logic dest_logical = 1'b0;
  logic [1:0] shorthand = '0;
  logic lowest_pri = 1'b0;
  logic [IDXW-1:0] sender_idx = '0;
  logic [N-1:0] core_present = 4'b1111;
  logic [N-1:0] core_ext = 4'b0100;
  logic [N-1:0] core_cluster = 4'b1010;
  logic [8*N-1:0] core_id = {8'h13, 8'h00, 8'h11, 8'h10};
  logic [32*N-1:0] core_xid = {32'h0, 32'h0000_0102, 32'h0, 32'h0};
  logic [8*N-1:0] core_ldr = {8'h21, 8'h00, 8'h12, 8'h01};
  logic [32*N-1:0] core_xldr = {32'h0, 32'h0003_0004, 32'h0, 32'h0};
  logic mask_valid;
  logic [N-1:0] target_mask;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  dest_mask_gen #(.N(N)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .dest_id(dest_id),
    .dest_logical(dest_logical), .shorthand(shorthand), .lowest_pri(lowest_pri),
    .sender_idx(sender_idx), .core_present(core_present), .core_ext(core_ext),
    .core_cluster(core_cluster), .core_id(core_id), .core_xid(core_xid),
    .core_ldr(core_ldr), .core_xldr(core_xldr), .mask_valid(mask_valid),
    .target_mask(target_mask)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] d, input logic lg, input logic [1:0] sh,
                       input logic lp, input logic [IDXW-1:0] snd,
                       input logic [N-1:0] exp, input string tag);
    @(negedge clk);
    dest_id = d; dest_logical = lg; shorthand = sh; lowest_pri = lp; sender_idx = snd;
    req_valid = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && mask_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected valid", 32'(target_mask), 32'h0);
      end else begin
        automatic logic [N-1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(target_mask === e, t, 32'(target_mask), 32'(e));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 32'h0, 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(mask_valid === 1'b0, "R1 reset valid", 32'(mask_valid), 32'h0);
    check(target_mask === '0, "R1 reset mask", 32'(target_mask), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    issue(32'h0, 1'b0, 2'd1, 1'b0, 2'd1, 4'b0010, "R3 self"); idle();
    @(negedge clk);
    check(mask_valid === 1'b0 && target_mask === 4'b0010, "R2 hold after pulse",
          {31'h0, mask_valid} << 4 | 32'(target_mask), 32'h2);

    issue(32'h0, 1'b0, 2'd2, 1'b0, 2'd0, 4'b1111, "R4 all");
    issue(32'h0, 1'b0, 2'd3, 1'b0, 2'd2, 4'b1011, "R4 all but self (back-to-back R2)");
    issue(32'h0000_0011, 1'b0, 2'd0, 1'b0, 2'd0, 4'b0010, "R5 phys 8-bit");
    issue(32'h0000_0102, 1'b0, 2'd0, 1'b0, 2'd0, 4'b0100, "R5 phys extended");
    issue(32'h0000_0110, 1'b0, 2'd0, 1'b0, 2'd0, 4'b0001, "R5 phys low byte only");
    issue(32'hFFFF_FFFF, 1'b0, 2'd0, 1'b0, 2'd0, 4'b1111, "R6 phys all-ones");
    issue(32'h0000_00FF, 1'b0, 2'd0, 1'b0, 2'd0, 4'b1011, "R6 phys FF non-ext");
    issue(32'h0000_0001, 1'b1, 2'd0, 1'b0, 2'd0, 4'b0001, "R7 flat hit");
    issue(32'h0000_0002, 1'b1, 2'd0, 1'b0, 2'd0, 4'b0000, "R7 flat miss");
    issue(32'h0000_0012, 1'b1, 2'd0, 1'b0, 2'd0, 4'b0010, "R8 cluster hit");
    issue(32'h0000_00F3, 1'b1, 2'd0, 1'b0, 2'd0, 4'b1011, "R8 cluster F broadcast");
    issue(32'h0000_0022, 1'b1, 2'd0, 1'b0, 2'd0, 4'b0000, "R8 cluster member miss");
    issue(32'h0003_0004, 1'b1, 2'd0, 1'b0, 2'd0, 4'b0100, "R9 ext logical hit");
    issue(32'h0003_0008, 1'b1, 2'd0, 1'b0, 2'd0, 4'b0000, "R9 ext logical no overlap");
    issue(32'h0002_0004, 1'b1, 2'd0, 1'b0, 2'd0, 4'b0000, "R9 ext logical cluster miss");
    issue(32'hFFFF_FFFF, 1'b1, 2'd0, 1'b0, 2'd0, 4'b1111, "R10 logical all-ones");
    issue(32'h0, 1'b0, 2'd2, 1'b1, 2'd0, 4'b0001, "R11 lowest of all");
    issue(32'h0000_0002, 1'b1, 2'd0, 1'b1, 2'd0, 4'b0000, "R11 lowest empty");
    idle();

    @(negedge clk); core_present = 4'b1110;
    issue(32'h0000_00FF, 1'b0, 2'd0, 1'b1, 2'd0, 4'b0010, "R11 lowest skips absent");
    idle();
    @(negedge clk); core_present = 4'b0111;
    issue(32'h0, 1'b0, 2'd2, 1'b0, 2'd0, 4'b0111, "R12 absent all");
    issue(32'h0, 1'b0, 2'd1, 1'b0, 2'd3, 4'b0000, "R12 absent self");
    idle();

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R2 missing results", 32'(exp_q.size()), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule